// File: doc/BRIEF.md
# Run-of-Four Equal Symbol Detector

This block watches a single serial bit that is sampled on every rising clock edge. It raises its output flag when the last four samples are all ones, and also when they are all zeros. Runs may overlap. While a run keeps going past four samples, the flag stays high on every further edge. When the symbol changes, the flag drops, and the new symbol starts a fresh count of one.

The machine is a Moore machine. Its state lives in nine flip-flops with a one-hot code:

- Bit 0 is the idle state.
- Bits 1 to 4 count runs of zeros of length 1, 2, 3 and "4 or more".
- Bits 5 to 8 count runs of ones of length 1, 2, 3 and "4 or more".

Each state bit has its own next-state equation. The flag is decoded from the two saturated bits alone, so it changes only at clock edges. A synchronous active-low reset returns the machine to idle. The state vector is also brought out, so a neighbouring block or a bench can see which count is active.

Top module: `run_det_top`

## Requirements
- R1: When `rst_n` is low at a rising edge, the state after that edge is idle (`state_o` = 9'b000000001, bit 0 high) and `z_o` is 0.
- R2: After four consecutive edges that sample `w_i` = 1, `z_o` is 1 and `state_o` bit 8 is high.
- R3: After four consecutive edges that sample `w_i` = 0, `z_o` is 1 and `state_o` bit 4 is high.
- R4: While a run of equal samples continues beyond four, `z_o` stays 1 after every further edge (overlap).
- R5: A sample that differs from the previous one gives a run length of 1. Bit 5 is set for a 1 and bit 1 for a 0, and `z_o` is 0 after that edge.
- R6: Exactly one bit of `state_o` is high at all times after reset. Bit k encodes these states:
  - 0: idle.
  - 1 to 4: zero runs of length 1, 2, 3 and 4 or more.
  - 5 to 8: one runs of length 1, 2, 3 and 4 or more.
- R7: `z_o` depends only on the state (bit 4 OR bit 8). A change of `w_i` between edges leaves `z_o` unchanged.
- R8: Reset is synchronous. Lowering `rst_n` between edges changes nothing until the next rising edge, and at that edge reset takes priority over the input.
- R9: A run of one, two or three equal samples gives `z_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; `w_i` is sampled on each edge |
| rst_n | input | 1 | Synchronous active-low reset to the idle state |
| w_i | input | 1 | Serial input symbol |
| z_o | output | 1 | High when the current run of equal samples is four or longer |
| state_o | output | 9 | One-hot state vector; bit meanings as in R6 |

## Verification
Two functions of this block can fall on the same edge:
- **Reset and run extension.** The machine sits in a saturated state with the input still holding the run, and reset arrives at that edge. The bench drives this case and expects the idle code with the flag low, not a held flag.
- **Run break and restart.** The input flips while the flag is high, so the old run ends and a new one of length one begins on the same edge. The bench expects the new symbol's first-count state with the flag low.

The bench provokes both cases in a fixed vector table and in directed steps. A biased random stream adds long runs and adds alternating stretches. Every case is judged against a run-length model kept in the bench.

// File: rtl/run_det_pkg.sv
// Package: shared index helpers for the run detector.
// Assumes the state vector is laid out as idle, then the zero-run chain,
// then the one-run chain, each chain RUN_LEN bits long.
package run_det_pkg;
    localparam int DEF_RUN_LEN = 4;

    // Bit index of the idle state.
    localparam int IDLE_IDX = 0;

    // Bit index of the zero-run state for run length k+1 (k from 0).
    function automatic int zero_idx(input int k);
        return 1 + k;
    endfunction

    // Bit index of the one-run state for run length k+1 (k from 0).
    function automatic int one_idx(input int k, input int run_len);
        return 1 + run_len + k;
    endfunction
endpackage

// File: rtl/run_det_next.sv
// Module: next-state equations for the one-hot run detector.
// One assign per flip-flop; no case statement. Assumes RUN_LEN >= 2 and a
// one-hot current state. The idle bit has a next value of 0: only reset
// returns there.
module run_det_next
    import run_det_pkg::*;
#(
    parameter int RUN_LEN = DEF_RUN_LEN,
    localparam int NUM_ST = 2 * RUN_LEN + 1,
    localparam int Z_LO   = 1,
    localparam int Z_HI   = RUN_LEN,
    localparam int O_LO   = RUN_LEN + 1,
    localparam int O_HI   = 2 * RUN_LEN
) (
    input  logic              w,
    input  logic [NUM_ST-1:0] cur,
    output logic [NUM_ST-1:0] nxt
);
    logic in_zero_run;
    logic in_one_run;

    // Purpose: collapse each chain to a single "currently in this run" flag.
    assign in_zero_run = |cur[Z_HI:Z_LO];
    assign in_one_run  = |cur[O_HI:O_LO];

    // Purpose: idle is never re-entered except through reset.
    assign nxt[IDLE_IDX] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < RUN_LEN; k++) begin : g_chain
            if (k == 0) begin : g_first
                // Purpose: a new symbol starts its chain from idle or the other chain.
                assign nxt[zero_idx(k)]         = ~w & (cur[IDLE_IDX] | in_one_run);
                assign nxt[one_idx(k, RUN_LEN)] =  w & (cur[IDLE_IDX] | in_zero_run);
            end else if (k == RUN_LEN - 1) begin : g_sat
                // Purpose: the last counter state holds itself while the run continues.
                assign nxt[zero_idx(k)] = ~w & (cur[zero_idx(k-1)] | cur[zero_idx(k)]);
                assign nxt[one_idx(k, RUN_LEN)] =
                    w & (cur[one_idx(k-1, RUN_LEN)] | cur[one_idx(k, RUN_LEN)]);
            end else begin : g_mid
                // Purpose: advance one step along the chain on an equal symbol.
                assign nxt[zero_idx(k)]         = ~w & cur[zero_idx(k-1)];
                assign nxt[one_idx(k, RUN_LEN)] =  w & cur[one_idx(k-1, RUN_LEN)];
            end
        end
    endgenerate
endmodule

// File: rtl/run_det_state.sv
// Module: one-hot state register with synchronous active-low reset.
// The idle bit is stored in inverted sense, so a reset value of 0 on every
// flop still yields the idle code. All other bits reset to 0.
module run_det_state
    import run_det_pkg::*;
#(
    parameter int RUN_LEN = DEF_RUN_LEN,
    localparam int NUM_ST = 2 * RUN_LEN + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_ST-1:0] nxt,
    output logic [NUM_ST-1:0] cur
);
    genvar b;
    generate
        for (b = 0; b < NUM_ST; b++) begin : g_bit
            if (b == IDLE_IDX) begin : g_inv
                logic held_n;
                // Purpose: inverted-sense flop so reset forces the idle bit to 1.
                always_ff @(posedge clk) begin
                    if (!rst_n) held_n <= 1'b0;
                    else        held_n <= ~nxt[b];
                end
                assign cur[b] = ~held_n;
            end else begin : g_pos
                logic held;
                // Purpose: plain state flop cleared by reset.
                always_ff @(posedge clk) begin
                    if (!rst_n) held <= 1'b0;
                    else        held <= nxt[b];
                end
                assign cur[b] = held;
            end
        end
    endgenerate

    // R6: exactly one state bit high at every edge out of reset.
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cur) == 1)
        else $error("state vector not one-hot");

    // R1: a reset edge lands in the idle code.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (cur == NUM_ST'(1)))
        else $error("reset did not reach idle");
endmodule

// File: rtl/run_det_out.sv
// Module: Moore output decode. Flag is high in either saturated run state.
// Assumes the current state is one-hot; uses no input.
module run_det_out
    import run_det_pkg::*;
#(
    parameter int RUN_LEN = DEF_RUN_LEN,
    localparam int NUM_ST = 2 * RUN_LEN + 1
) (
    input  logic [NUM_ST-1:0] cur,
    output logic              z
);
    // Purpose: OR of the two "run of RUN_LEN or more" state bits.
    assign z = cur[zero_idx(RUN_LEN-1)] | cur[one_idx(RUN_LEN-1, RUN_LEN)];
endmodule

// File: rtl/run_det_top.sv
// Module: run-of-equal-symbols detector top.
// Samples w_i on each rising edge. z_o is high once the current run of equal
// samples reaches RUN_LEN, and overlapping runs keep it high. Synchronous
// active-low reset. state_o exposes the one-hot state.
module run_det_top
    import run_det_pkg::*;
#(
    parameter int RUN_LEN = DEF_RUN_LEN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 w_i,
    output logic                 z_o,
    output logic [2*RUN_LEN:0]   state_o
);
    localparam int NUM_ST = 2 * RUN_LEN + 1;
    localparam int Z_SAT  = RUN_LEN;
    localparam int O_SAT  = 2 * RUN_LEN;
    localparam int Z_PRE  = RUN_LEN - 1;
    localparam int O_PRE  = 2 * RUN_LEN - 1;
    localparam int Z_ONE  = 1;
    localparam int O_ONE  = RUN_LEN + 1;

    logic [NUM_ST-1:0] cur;
    logic [NUM_ST-1:0] nxt;

    run_det_next #(.RUN_LEN(RUN_LEN)) u_next (
        .w   (w_i),
        .cur (cur),
        .nxt (nxt)
    );

    run_det_state #(.RUN_LEN(RUN_LEN)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt),
        .cur   (cur)
    );

    run_det_out #(.RUN_LEN(RUN_LEN)) u_out (
        .cur (cur),
        .z   (z_o)
    );

    // Purpose: expose the one-hot state.
    assign state_o = cur;

    // R2: the last missing one completes a run of ones and raises the flag.
    p_ones_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (w_i && cur[O_PRE]) |=> z_o)
        else $error("one-run did not raise flag");

    // R3: the last missing zero completes a run of zeros and raises the flag.
    p_zeros_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!w_i && cur[Z_PRE]) |=> z_o)
        else $error("zero-run did not raise flag");

    // R4: a saturated run that continues keeps the flag high.
    p_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((w_i && cur[O_SAT]) || (!w_i && cur[Z_SAT])) |=> z_o)
        else $error("overlapping run dropped flag");

    // R5: a symbol change restarts the count at one with the flag low.
    p_break_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (w_i && cur[Z_SAT]) |=> (cur[O_ONE] && !z_o))
        else $error("zero-run break did not restart");

    p_break_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!w_i && cur[O_SAT]) |=> (cur[Z_ONE] && !z_o))
        else $error("one-run break did not restart");
endmodule

// File: tb/tb_run_det_top.sv
// Bench: vector table walk, then directed reset, Moore and random checks.
module tb_run_det_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       w_i = 1'b0;
    logic       z_o;
    logic [8:0] state_o;

    int n_run  = 0;
    int n_fail = 0;
    int run_cnt = 0;
    logic last_w = 1'b0;

    always #2 clk = ~clk;

    run_det_top dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .w_i     (w_i),
        .z_o     (z_o),
        .state_o (state_o)
    );

    // {w, expected z}, applied from idle
    localparam logic [1:0] VEC [0:19] = '{
        2'b10, 2'b10, 2'b10, 2'b11, 2'b11,
        2'b00, 2'b00, 2'b00, 2'b01, 2'b01,
        2'b10, 2'b00, 2'b10, 2'b00, 2'b00,
        2'b00, 2'b10, 2'b10, 2'b10, 2'b00
    };

    function automatic logic [8:0] model_state(input int cnt, input logic sym);
        int c;
        c = (cnt > 4) ? 4 : cnt;
        if (cnt == 0) return 9'b1;
        return 9'b1 << (sym ? (4 + c) : c);
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // drive w just after an edge, let one edge pass, update model
    task automatic step(input logic wv);
        w_i = wv;
        @(posedge clk);
        #1;
        if (!rst_n) run_cnt = 0;
        else if (run_cnt == 0 || wv != last_w) run_cnt = 1;
        else run_cnt++;
        last_w = wv;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        step(1'b1);
        step(1'b0);
        check("R1 reset state", state_o, 9'b1);
        check("R1 reset z", {8'b0, z_o}, 9'b0);
        rst_n = 1'b1;

        // table walk: R2 R3 R4 R5 R9
        for (int i = 0; i < 20; i++) begin
            step(VEC[i][1]);
            check("R2/R3/R4/R5/R9 table z", {8'b0, z_o}, {8'b0, VEC[i][0]});
            check("R6 table state", state_o, model_state(run_cnt, last_w));
        end

        // R2 with R4: long run of ones
        for (int i = 0; i < 7; i++) step(1'b1);
        check("R2 ones state bit 8", state_o, 9'h100);
        check("R4 long run z", {8'b0, z_o}, 9'd1);

        // R7: w changes between edges, z holds
        w_i = 1'b0;
        #1;
        check("R7 z stable mid-cycle", {8'b0, z_o}, 9'd1);

        // R5: break from saturated ones
        step(1'b0);
        check("R5 break to zero count 1", state_o, 9'h002);
        check("R5 break z", {8'b0, z_o}, 9'd0);

        // R3: zeros to saturation
        for (int i = 0; i < 3; i++) step(1'b0);
        check("R3 zeros state bit 4", state_o, 9'h010);
        check("R3 zeros z", {8'b0, z_o}, 9'd1);

        // R5: break from saturated zeros
        step(1'b1);
        check("R5 break to one count 1", state_o, 9'h020);

        // R8: reset lowered between edges waits for the edge, wins over run
        for (int i = 0; i < 4; i++) step(1'b1);
        rst_n = 1'b0;
        w_i = 1'b1;
        #1;
        check("R8 reset waits for edge", state_o, 9'h100);
        step(1'b1);
        check("R8 reset wins over run", state_o, 9'b1);
        check("R1 z after reset", {8'b0, z_o}, 9'd0);
        rst_n = 1'b1;

        // R9: alternating pattern never flags
        for (int i = 0; i < 24; i++) begin
            step(i[0]);
            check("R9 alternating z", {8'b0, z_o}, 9'd0);
        end

        // random biased stream against the run-length model
        for (int i = 0; i < 600; i++) begin
            logic nv;
            nv = (($urandom % 8) < 6) ? last_w : ~last_w;
            step(nv);
            check("R6 random state", state_o, model_state(run_cnt, last_w));
            check("R4 random z", {8'b0, z_o}, {8'b0, run_cnt >= 4});
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule